// File: doc/BRIEF.md
# Touch Digitizer Serial Conversion Sequencer

This block is the device-side digital sequencer of a 12-bit successive-approximation touch-screen converter. It runs entirely from the serial clock `dclk` while the active-low select `cs_n` is held low. It watches the serial data input for a start bit, gathers an 8-bit command word and exposes its fields as they arrive. It then marks a three-clock acquisition window for the track/hold and runs a bit-by-bit successive-approximation search. The search drives a trial code to an external capacitor DAC and reads back a single comparator bit. Each decided bit leaves on `dout`, MSB first.

The command receiver keeps scanning for the next start bit while a conversion is still shifting out. The receiver is locked out for a shorter window after an 8-bit command than after a 12-bit one. Back-to-back conversions can therefore be packed at 15 clocks (12-bit) or 11 clocks (8-bit) each, instead of a fixed 24-clock frame. Raising `cs_n` clears everything at once.

The parallel result leaves as a stream: `result_valid` is a one-clock pulse qualifying `result`. There is no ready input and no back-pressure, so the consumer must capture the word in the cycle the pulse is high. The value is overwritten by the next conversion.

Top module: `touch_seq`

## Requirements
- R1: While idle and unlocked, `din` is ignored until a 1 is sampled on a rising `dclk` edge. That 1 is the first bit of an 8-bit command word sent MSB first with this order: start(1), channel[2:0] (MSB first), mode (1 = 8-bit, 0 = 12-bit), single-ended reference select, power bits [1:0].
- R2: Counting the start bit's rising edge as edge 1, `chan` takes the channel field at edge 4, `mode8` and `single_ended` update at edge 6, and `pd` updates at edge 8. While `cs_n` is high all three fields read 0.
- R3: `track` is high after falling edges 5, 6 and 7 and low after falling edge 8. `busy` is high for exactly one `dclk` period, from falling edge 8 to falling edge 9.
- R4: In 12-bit mode, `sar_trial` reads 0x800 for the first decision. `cmp` is sampled on rising edges 9 to 20, and each sample keeps (1) or clears (0) the current trial bit. The result is straight binary, and equals the input code when `cmp` = (input code >= `sar_trial`).
- R5: In 8-bit mode only trial bits 11 down to 4 are decided, on rising edges 9 to 16. The result is reported zero-extended in `result[7:0]`.
- R6: `dout` is 0 after falling edges 1 to 8. After falling edges 9 onward it carries the decided bits MSB first, one per edge, and it returns to 0 after the last one.
- R7: `result_valid` pulses for one clock, registered on the rising edge of the last decision (edge 20 in 12-bit mode, edge 16 in 8-bit mode), with `result` valid in the same cycle.
- R8: After edge 8 of a command, `din` is ignored for the next 7 rising edges (12-bit) or 3 rising edges (8-bit). A new start bit is accepted from edge 16 or edge 12 respectively, overlapping the running conversion.
- R9: `cs_n` high asynchronously aborts any command or conversion. It drives `out_en`, `dout`, `busy`, `track` and `result_valid` low, and no result from the aborted conversion appears after `cs_n` falls again.
- R10: With `cs_n` held low, the sequencer returns to scanning after each conversion and accepts further commands without a new select frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial and conversion clock |
| cs_n | input | 1 | Active-low select; high clears and aborts |
| din | input | 1 | Serial command input, sampled on rising edges |
| cmp | input | 1 | Comparator decision for the current trial code |
| dout | output | 1 | Serial result, updated on falling edges |
| busy | output | 1 | One-period pulse at entry to hold |
| out_en | output | 1 | Drive enable for `dout` and `busy` (high while selected) |
| track | output | 1 | Track/hold in acquisition when high |
| sar_trial | output | 12 | Trial code to the capacitor DAC |
| chan | output | 3 | Channel field of the latest command |
| mode8 | output | 1 | Resolution field of the latest command |
| single_ended | output | 1 | Reference-select field of the latest command |
| pd | output | 2 | Power field of the latest command |
| result | output | 12 | Parallel conversion result |
| result_valid | output | 1 | Qualifies `result` for one clock |

## Verification
The bench builds the block with its defaults: 12-bit and 8-bit resolutions, an 8-edge and a 4-edge lock-out, and a 3-clock acquisition window. With these values the tightest packing is reachable: 15-clock and 11-clock spacing, mixed-resolution chains, and start-like ones placed on every locked-out edge. Full-scale and zero codes exercise both ends of the search. Random command words with random spacing cover every channel, reference and power field, and a mid-conversion deselect tests the abort.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;
  // command word length and derived counter width
  localparam int CTRL_BITS = 8;
  localparam int CNT_W     = $clog2(CTRL_BITS + 1);
  // bit counts at which staged fields are complete (start bit counts as 1)
  localparam int CH_AT     = 3;   // channel LSB arrives on this count
  localparam int CFG_AT    = 5;   // reference select arrives on this count
  // index of the resolution bit inside the full word (LSB = 0)
  localparam int MODE_BIT  = 3;
endpackage

// File: rtl/touch_seq_rx.sv
module touch_seq_rx
  import touch_seq_pkg::*;
#(
  parameter int LOCK_FULL  = 8,
  parameter int LOCK_SHORT = 4
) (
  input  logic             dclk,
  input  logic             cs_n,
  input  logic             din,
  output logic             fire,
  output logic             fire_lo,
  output logic             rx_on,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [2:0]       chan,
  output logic             mode8,
  output logic             single_ended,
  output logic [1:0]       pd
);
  localparam int LOCK_W = (LOCK_FULL > 1) ? $clog2(LOCK_FULL) : 1;

  logic [CTRL_BITS-2:0] shreg;
  logic [LOCK_W-1:0]    lock_cnt;

  // last command bit is on din while CTRL_BITS-1 bits are held
  assign fire    = rx_on && (bit_cnt == CNT_W'(CTRL_BITS - 1));
  assign fire_lo = shreg[MODE_BIT-1];

  always_ff @(posedge dclk or posedge cs_n) begin
    if (cs_n) begin
      rx_on        <= 1'b0;
      bit_cnt      <= '0;
      shreg        <= '0;
      lock_cnt     <= '0;
      chan         <= '0;
      mode8        <= 1'b0;
      single_ended <= 1'b0;
      pd           <= '0;
    end else if (lock_cnt != '0) begin
      lock_cnt <= lock_cnt - 1'b1;
    end else if (!rx_on) begin
      if (din) begin
        rx_on   <= 1'b1;
        bit_cnt <= CNT_W'(1);
        shreg   <= {{(CTRL_BITS-2){1'b0}}, 1'b1};
      end
    end else begin
      shreg   <= {shreg[CTRL_BITS-3:0], din};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(CH_AT)) begin
        chan <= {shreg[1:0], din};
      end
      if (bit_cnt == CNT_W'(CFG_AT)) begin
        mode8        <= shreg[0];
        single_ended <= din;
      end
      if (fire) begin
        pd       <= {shreg[0], din};
        rx_on    <= 1'b0;
        bit_cnt  <= '0;
        lock_cnt <= fire_lo ? LOCK_W'(LOCK_SHORT - 1) : LOCK_W'(LOCK_FULL - 1);
      end
    end
  end
endmodule

// File: rtl/touch_seq_sar.sv
module touch_seq_sar #(
  parameter int RES_BITS = 12,
  parameter int LO_BITS  = 8
) (
  input  logic                dclk,
  input  logic                cs_n,
  input  logic                load,
  input  logic                load_lo,
  input  logic                cmp,
  output logic [RES_BITS-1:0] sar,
  output logic                bit_vld,
  output logic                bit_val,
  output logic                hold,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid
);
  localparam int STEP_W = $clog2(RES_BITS + 1);
  localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

  logic              active;
  logic              lo;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] last;
  logic [STEP_W-1:0] idx;
  logic [RES_BITS-1:0] onehot;
  logic [RES_BITS-1:0] nxt;
  logic [RES_BITS-1:0] res_val;

  always_comb begin
    last   = lo ? STEP_W'(LO_BITS - 1) : STEP_W'(RES_BITS - 1);
    idx    = STEP_W'(RES_BITS - 1) - step;
    onehot = ONE << idx;
    nxt    = cmp ? sar : (sar & ~onehot);
    if (step != last) begin
      nxt = nxt | (onehot >> 1);
    end
    res_val = lo ? (nxt >> (RES_BITS - LO_BITS)) : nxt;
  end

  always_ff @(posedge dclk or posedge cs_n) begin
    if (cs_n) begin
      active       <= 1'b0;
      lo           <= 1'b0;
      step         <= '0;
      sar          <= '0;
      bit_vld      <= 1'b0;
      bit_val      <= 1'b0;
      hold         <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      hold         <= 1'b0;
      bit_vld      <= 1'b0;
      result_valid <= 1'b0;
      if (load) begin
        active <= 1'b1;
        lo     <= load_lo;
        step   <= '0;
        sar    <= ONE << (RES_BITS - 1);
        hold   <= 1'b1;
      end else if (active) begin
        sar     <= nxt;
        bit_vld <= 1'b1;
        bit_val <= cmp;
        step    <= step + 1'b1;
        if (step == last) begin
          active       <= 1'b0;
          result       <= res_val;
          result_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/touch_seq_out.sv
module touch_seq_out
  import touch_seq_pkg::*;
#(
  parameter int ACQ_CYCLES = 3
) (
  input  logic             dclk,
  input  logic             cs_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             hold,
  input  logic             rx_on,
  input  logic [CNT_W-1:0] bit_cnt,
  output logic             dout,
  output logic             busy,
  output logic             track
);
  localparam int ACQ_FIRST = CTRL_BITS - ACQ_CYCLES;

  always_ff @(negedge dclk or posedge cs_n) begin
    if (cs_n) begin
      dout  <= 1'b0;
      busy  <= 1'b0;
      track <= 1'b0;
    end else begin
      dout  <= bit_vld & bit_val;
      busy  <= hold;
      track <= rx_on && (bit_cnt >= CNT_W'(ACQ_FIRST))
                     && (bit_cnt <= CNT_W'(CTRL_BITS - 1));
    end
  end
endmodule

// File: rtl/touch_seq.sv
module touch_seq
  import touch_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int LO_BITS    = 8,
  parameter int ACQ_CYCLES = 3,
  parameter int LOCK_FULL  = 8,
  parameter int LOCK_SHORT = 4
) (
  input  logic                dclk,
  input  logic                cs_n,
  input  logic                din,
  input  logic                cmp,
  output logic                dout,
  output logic                busy,
  output logic                out_en,
  output logic                track,
  output logic [RES_BITS-1:0] sar_trial,
  output logic [2:0]          chan,
  output logic                mode8,
  output logic                single_ended,
  output logic [1:0]          pd,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid
);
  logic             fire;
  logic             fire_lo;
  logic             rx_on;
  logic [CNT_W-1:0] bit_cnt;
  logic             bit_vld;
  logic             bit_val;
  logic             hold;

  assign out_en = ~cs_n;

  touch_seq_rx #(
    .LOCK_FULL (LOCK_FULL),
    .LOCK_SHORT(LOCK_SHORT)
  ) u_rx (
    .dclk        (dclk),
    .cs_n        (cs_n),
    .din         (din),
    .fire        (fire),
    .fire_lo     (fire_lo),
    .rx_on       (rx_on),
    .bit_cnt     (bit_cnt),
    .chan        (chan),
    .mode8       (mode8),
    .single_ended(single_ended),
    .pd          (pd)
  );

  touch_seq_sar #(
    .RES_BITS(RES_BITS),
    .LO_BITS (LO_BITS)
  ) u_sar (
    .dclk        (dclk),
    .cs_n        (cs_n),
    .load        (fire),
    .load_lo     (fire_lo),
    .cmp         (cmp),
    .sar         (sar_trial),
    .bit_vld     (bit_vld),
    .bit_val     (bit_val),
    .hold        (hold),
    .result      (result),
    .result_valid(result_valid)
  );

  touch_seq_out #(
    .ACQ_CYCLES(ACQ_CYCLES)
  ) u_out (
    .dclk   (dclk),
    .cs_n   (cs_n),
    .bit_vld(bit_vld),
    .bit_val(bit_val),
    .hold   (hold),
    .rx_on  (rx_on),
    .bit_cnt(bit_cnt),
    .dout   (dout),
    .busy   (busy),
    .track  (track)
  );
endmodule

// File: rtl/touch_seq_chk.sv
module touch_seq_chk
  import touch_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int LOCK_SHORT = 4
) (
  input logic                dclk,
  input logic                cs_n,
  input logic                busy,
  input logic                track,
  input logic                dout,
  input logic                result_valid,
  input logic [RES_BITS-1:0] sar_trial
);
  localparam int MIN_GAP = CTRL_BITS + LOCK_SHORT - 2;
  localparam logic [RES_BITS-1:0] MSB_TRIAL = RES_BITS'(1) << (RES_BITS - 1);

  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge dclk or posedge cs_n) begin
    if (cs_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (busy) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R3: busy lasts a single period
  p_busy_single_r3: assert property (@(posedge dclk) disable iff (cs_n)
    busy |=> !busy);

  // R3: hold entry follows the acquisition window
  p_track_then_busy_r3: assert property (@(posedge dclk) disable iff (cs_n)
    $rose(busy) |-> $past(track));

  // R4: the search opens on the MSB trial code
  p_msb_trial_r4: assert property (@(posedge dclk) disable iff (cs_n)
    busy |-> (sar_trial == MSB_TRIAL));

  // R6: no data bit is driven during the hold-entry period
  p_quiet_at_hold_r6: assert property (@(posedge dclk) disable iff (cs_n)
    busy |-> !dout);

  // R7: result strobe is a single-clock pulse
  p_valid_pulse_r7: assert property (@(posedge dclk) disable iff (cs_n)
    result_valid |=> !result_valid);

  // R8: lock-out keeps conversions at least the short spacing apart
  p_min_spacing_r8: assert property (@(posedge dclk) disable iff (cs_n)
    (busy && seen) |-> (gap >= 8'(MIN_GAP)));
endmodule

bind touch_seq touch_seq_chk #(
  .RES_BITS  (RES_BITS),
  .LOCK_SHORT(LOCK_SHORT)
) u_chk (
  .dclk        (dclk),
  .cs_n        (cs_n),
  .busy        (busy),
  .track       (track),
  .dout        (dout),
  .result_valid(result_valid),
  .sar_trial   (sar_trial)
);

// File: tb/touch_seq_bench.sv
module touch_seq_bench;
  localparam int MAXK = 1024;

  logic        dclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        din  = 1'b0;
  logic [11:0] vin  = '0;
  logic        cmp;
  logic        dout, busy, out_en, track, mode8, single_ended, result_valid;
  logic [11:0] sar_trial, result;
  logic [2:0]  chan;
  logic [1:0]  pd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // stimulus and expectation per clock index k (sampled after falling edge k)
  bit          din_at  [MAXK];
  logic [11:0] vin_at  [MAXK];
  bit          e_dout  [MAXK];
  bit          e_busy  [MAXK];
  bit          e_track [MAXK];
  bit          e_rv    [MAXK];
  bit          e_lo    [MAXK];
  logic [11:0] e_res   [MAXK];
  bit          ev_ch   [MAXK];
  logic [2:0]  ev_chv  [MAXK];
  bit          ev_cfg  [MAXK];
  logic [1:0]  ev_cfgv [MAXK];
  bit          ev_pd   [MAXK];
  logic [1:0]  ev_pdv  [MAXK];

  always #2 dclk = ~dclk;

  // comparator model of the analog front end
  assign cmp = (vin >= sar_trial);

  touch_seq u_touch_seq (
    .dclk(dclk), .cs_n(cs_n), .din(din), .cmp(cmp),
    .dout(dout), .busy(busy), .out_en(out_en), .track(track),
    .sar_trial(sar_trial), .chan(chan), .mode8(mode8),
    .single_ended(single_ended), .pd(pd),
    .result(result), .result_valid(result_valid)
  );

  task automatic chk(input bit ok, input string tag, input int k,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at clock %0d: got %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int k = 0; k < MAXK; k++) begin
      din_at[k] = 0; vin_at[k] = '0; e_dout[k] = 0; e_busy[k] = 0;
      e_track[k] = 0; e_rv[k] = 0; e_lo[k] = 0; e_res[k] = '0;
      ev_ch[k] = 0; ev_chv[k] = '0; ev_cfg[k] = 0; ev_cfgv[k] = '0;
      ev_pd[k] = 0; ev_pdv[k] = '0;
    end
  endtask

  // expected timeline of one command starting at clock s
  task automatic add_conv(input int s, input logic [7:0] w, input logic [11:0] code);
    int n;
    logic [11:0] v;
    n = w[3] ? 8 : 12;
    v = w[3] ? {4'b0, code[11:4]} : code;
    for (int i = 0; i < 8; i++) din_at[s+i] = w[7-i];
    for (int i = 4; i <= 6; i++) e_track[s+i] = 1;
    e_busy[s+7] = 1;
    for (int i = 0; i < n; i++) begin
      e_dout[s+8+i] = v[n-1-i];
      vin_at[s+8+i] = code;
    end
    e_rv[s+7+n] = 1; e_res[s+7+n] = v; e_lo[s+7+n] = w[3];
    ev_ch[s+3]  = 1; ev_chv[s+3]  = w[6:4];
    ev_cfg[s+5] = 1; ev_cfgv[s+5] = w[3:2];
    ev_pd[s+7]  = 1; ev_pdv[s+7]  = w[1:0];
  endtask

  // lock-out noise: ones the receiver must ignore (R8)
  task automatic add_noise(input int s, input logic [7:0] w, input bit rnd);
    int l;
    l = w[3] ? 4 : 8;
    for (int q = s + 8; q <= s + 6 + l; q++) din_at[q] = rnd ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic run_seq(input int n);
    logic [2:0] c_ch;
    logic [1:0] c_cfg, c_pd;
    c_ch = '0; c_cfg = '0; c_pd = '0;
    for (int k = 1; k <= n; k++) begin
      din = din_at[k];
      vin = vin_at[k];
      @(posedge dclk);
      @(negedge dclk);
      #1;
      if (ev_ch[k])  c_ch  = ev_chv[k];
      if (ev_cfg[k]) c_cfg = ev_cfgv[k];
      if (ev_pd[k])  c_pd  = ev_pdv[k];
      chk(out_en == 1'b1, "R9 out_en", k, out_en, 1);
      chk(busy == e_busy[k], "R1/R3/R8 busy", k, busy, e_busy[k]);
      chk(track == e_track[k], "R3 track", k, track, e_track[k]);
      chk(dout == e_dout[k], "R6 dout", k, dout, e_dout[k]);
      chk(result_valid == e_rv[k], "R7/R10 result_valid", k, result_valid, e_rv[k]);
      if (e_rv[k])
        chk(result == e_res[k], e_lo[k] ? "R5 result" : "R4 result", k, result, e_res[k]);
      chk(chan == c_ch, "R2 chan", k, chan, c_ch);
      chk({mode8, single_ended} == c_cfg, "R2 mode/ref", k, {mode8, single_ended}, c_cfg);
      chk(pd == c_pd, "R2 pd", k, pd, c_pd);
    end
    din = 0;
  endtask

  task automatic check_idle(input string tag);
    chk(out_en == 0, tag, 0, out_en, 0);
    chk(dout == 0, tag, 0, dout, 0);
    chk(busy == 0, tag, 0, busy, 0);
    chk(track == 0, tag, 0, track, 0);
    chk(result_valid == 0, tag, 0, result_valid, 0);
    chk({chan, mode8, single_ended, pd} == 7'd0, tag, 0, {chan, mode8, single_ended, pd}, 0);
  endtask

  task automatic select();
    repeat (3) @(negedge dclk);
    #1 cs_n = 1'b0;
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    #1;
  endtask

  task automatic build_random(input int len);
    int p;
    logic [7:0]  w;
    logic [11:0] code;
    p = 1 + int'($urandom % 10);
    while (p + 30 < len) begin
      w = {1'b1, 7'($urandom)};
      case ($urandom % 6)
        0: code = 12'h000;
        1: code = 12'hFFF;
        default: code = 12'($urandom);
      endcase
      add_conv(p, w, code);
      add_noise(p, w, 1'b1);
      p = p + 7 + (w[3] ? 4 : 8);
      if ($urandom % 3 == 0) p = p + int'($urandom % 6);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge dclk);
    #1;
    // R9 / R2: deselected state
    check_idle("R9/R2 reset state");

    // directed: tightest mixed packing, end codes, full lock-out noise
    clear_exp();
    add_conv(1,  8'b1_101_0_0_11, 12'hFFF);
    add_noise(1, 8'b1_101_0_0_11, 1'b0);
    add_conv(16, 8'b1_011_1_1_00, 12'h7F3);
    add_noise(16, 8'b1_011_1_1_00, 1'b0);
    add_conv(27, 8'b1_110_1_0_01, 12'h800);
    add_conv(45, 8'b1_000_0_1_10, 12'h000);
    add_conv(60, 8'b1_111_0_0_01, 12'hA5C);
    select();
    run_seq(90);
    deselect();
    check_idle("R9 after frame");

    // abort mid-conversion, then a fresh frame (R9)
    clear_exp();
    add_conv(5, 8'b1_001_0_1_11, 12'h5A3);
    select();
    run_seq(14);
    deselect();
    check_idle("R9 abort");
    din = 1'b1;
    repeat (5) @(negedge dclk);
    #1;
    check_idle("R9 din ignored while deselected");
    din = 1'b0;
    clear_exp();
    add_conv(3, 8'b1_100_0_0_10, 12'h3C1);
    select();
    run_seq(40);
    deselect();

    // random command streams held under one select each (R10)
    for (int r = 0; r < 6; r++) begin
      clear_exp();
      build_random(600);
      select();
      run_seq(600);
      deselect();
      check_idle("R9 end of random frame");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule